// File: doc/BRIEF.md
# Averaging Rate Filter with Deadband

This block turns a stream of noisy 10-bit converter readings from a control knob into a steady 24-bit rate word for a low-frequency oscillator. Each completed conversion is marked by a one-cycle strobe. The block sums a block of 256 such readings, scales the sum down by four, and adds a fixed minimum-rate offset to form a candidate rate.

The candidate replaces the current rate only when it has moved by at least one converter step from the value already held. Smaller wobbles are discarded, so knob noise does not reach the oscillator. The running sum is emptied after every block, whether or not the rate changed. A single-cycle flag marks each cycle in which a new rate was taken.

Top module: `ctrl_rate_filter`

## Requirements
- R1: While reset is asserted and after it is released, `rate` reads 0x001000 and `rate_updated` reads 0. The internal strobe count and sum start at zero.
- R2: `conv_data` is summed only in cycles where `conv_done` is 1. Values present in any other cycle have no effect on `rate`.
- R3: A block ends on the 256th strobe. `rate` and `rate_updated` do not change in any cycle other than the one that takes the last strobe of a block.
- R4: The candidate is (sum of the block's 256 readings, with the reading of the final strobe included) shifted right by 2, plus 0x000100. A block of all-zero readings therefore gives the candidate 0x000100.
- R5: When the candidate is greater than `rate` by 0x40 or more, `rate` takes the candidate. When it is greater by 0x3F or less, `rate` is kept.
- R6: When the candidate is below `rate`, the magnitude is formed as the ones' complement of the negative difference, that is rate - candidate - 1. `rate` takes the candidate only if rate - candidate is 0x41 or more. At exactly 0x40 below, `rate` is kept.
- R7: The sum and the strobe count restart from zero after every block, including blocks that leave `rate` unchanged.
- R8: `rate` and `rate_updated` change on the clock edge that captures the final strobe of a block. `rate_updated` is high for exactly that one cycle, and only when `rate` changed.
- R9: A candidate equal to the current `rate` leaves `rate` unchanged and `rate_updated` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe marking a completed conversion |
| conv_data | input | 10 | Conversion result, unsigned |
| rate | output | 24 | Current filtered oscillator rate |
| rate_updated | output | 1 | High for one cycle when `rate` takes a new value |

## Verification
Both results are registered. A block's outcome is therefore visible right after the rising edge that captures its 256th strobe, and the bench reads it at the following falling edge plus a small delay. The driver queues the expected rate and flag at that falling edge. The monitor compares them against the outputs in the same sampling slot. In every other sampling slot, the monitor requires that `rate` equals the last expected value and that the flag is low, so an update that comes early, late or twice is caught.

// File: rtl/ctrl_rate_filter.sv
module ctrl_rate_filter #(
  parameter int ADC_W       = 10,
  parameter int RATE_W      = 24,
  parameter int BLOCK_LOG2  = 8,
  parameter int SCALE_SHIFT = 2,
  parameter logic [RATE_W-1:0] MIN_RATE   = 24'h000100,
  parameter logic [RATE_W-1:0] DEADBAND   = 24'h000040,
  parameter logic [RATE_W-1:0] RESET_RATE = 24'h001000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [ADC_W-1:0]  conv_data,
  output logic [RATE_W-1:0] rate,
  output logic              rate_updated
);

  localparam int PAD_W = RATE_W - ADC_W;

  logic [BLOCK_LOG2-1:0] count;
  logic [RATE_W-1:0]     acc;
  logic [RATE_W-1:0]     sum;
  logic [RATE_W-1:0]     cand;
  logic [RATE_W-1:0]     mag;
  logic [RATE_W:0]       diff;
  logic                  block_end;
  logic                  take;

  assign block_end = conv_done && (count == '1);
  assign sum       = acc + {{PAD_W{1'b0}}, conv_data};
  assign cand      = (sum >> SCALE_SHIFT) + MIN_RATE;
  assign diff      = {1'b0, cand} - {1'b0, rate};
  assign mag       = diff[RATE_W] ? ~diff[RATE_W-1:0] : diff[RATE_W-1:0];
  assign take      = block_end && (mag >= DEADBAND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count        <= '0;
      acc          <= '0;
      rate         <= RESET_RATE;
      rate_updated <= 1'b0;
    end else begin
      rate_updated <= take;
      if (conv_done) begin
        count <= count + 1'b1;
        acc   <= block_end ? '0 : sum;
      end
      if (take) rate <= cand;
    end
  end

  a_r2_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(count) && $stable(acc));

  a_r3_rate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(rate) && !rate_updated);

  a_r8_flag_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    rate_updated |-> rate != $past(rate));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rate_updated |=> !rate_updated);

  a_r8_change_means_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_updated |-> $stable(rate));

  a_r6_deadband_margin: assert property (@(posedge clk) disable iff (!rst_n)
    rate_updated |-> ((rate > $past(rate)) ? ((rate - $past(rate)) >= DEADBAND)
                                           : (($past(rate) - rate) > DEADBAND)));

  a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rate >= MIN_RATE);

endmodule

// File: tb/ctrl_rate_filter_tb.sv
module ctrl_rate_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic [23:0] rate;
  logic        rate_updated;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit live   = 1'b0;

  logic [23:0] model_rate = 24'h001000;
  logic [24:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  ctrl_rate_filter u_dut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done),
    .conv_data(conv_data), .rate(rate), .rate_updated(rate_updated)
  );

  task automatic check(string req, logic [24:0] act, logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual rate=%h flag=%b expected rate=%h flag=%b",
               req, act[24:1], act[0], exp[24:1], exp[0]);
    end
  endtask

  task automatic run_block(int total, string req);
    int base = total / 256;
    int rem  = total % 256;
    logic [23:0] cand;
    logic [24:0] d;
    logic [23:0] mag;
    bit upd;
    for (int i = 0; i < 256; i++) begin
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        conv_done = 1'b0;
        conv_data = 10'($urandom);
      end
      @(negedge clk);
      conv_done = 1'b1;
      conv_data = 10'((i < rem) ? base + 1 : base);
    end
    @(negedge clk);
    conv_done = 1'b0;
    conv_data = 10'($urandom);
    cand = 24'(total >> 2) + 24'h000100;
    d    = {1'b0, cand} - {1'b0, model_rate};
    mag  = d[24] ? ~d[23:0] : d[23:0];
    upd  = (mag >= 24'h40);
    if (upd) model_rate = cand;
    exp_q.push_back({model_rate, upd});
    tag_q.push_back(req);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (live) begin
        if (exp_q.size() > 0) check(tag_q.pop_front(), {rate, rate_updated}, exp_q.pop_front());
        else check("R3 hold between block ends", {rate, rate_updated}, {model_rate, 1'b0});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R1 reset value", {rate, rate_updated}, {24'h001000, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {rate, rate_updated}, {24'h001000, 1'b0});
    live = 1'b1;
    run_block(24'hF3F * 4 + 3, "R5 up by 0x3F kept, R2 gaps ignored");
    run_block(24'hF40 * 4,     "R5 up by 0x40 taken, R7 fresh sum");
    run_block(24'hF00 * 4 + 2, "R6 down by 0x40 kept");
    run_block(24'hEFF * 4,     "R6 down by 0x41 taken");
    run_block(0,               "R4 zero input gives minimum");
    run_block(1023 * 256,      "R4 full scale, R8 pulse");
    run_block(1023 * 256,      "R9 equal candidate kept");
    run_block(1023 * 256 - 3,  "R7 no carry over, kept");
    run_block(24'hC000 * 4,    "R6 large drop taken");
    repeat (4) @(negedge clk);
    live = 1'b0;
    finish_run();
  end

endmodule